// File: doc/BRIEF.md
# Clock and Reset Status Flag Register

This block is the 8-bit flag register of a clock, reset and power management unit. It records three kinds of information:

- **Reset causes:** power-on, low-voltage and illegal-address reset.
- **Periodic timer:** a flag that is set each time the timer period ends.
- **Two clock status bits and their change flags:** a PLL-lock status bit and an oscillator-qualified status bit. Each is live and read-only. Each has a change flag that is set whenever the status bit moves, whether it rises or falls.

Software reads the whole register on a simple bus. It clears any flag by writing 1 to that flag's bit. A registered interrupt request combines the timer flag, the lock-change flag and the oscillator-change flag, each gated by its own enable.

The PLL, the oscillator, the reset generator and the timer counter are all outside the block. Each of them delivers its result as a pulse or a level on an input of this block.

The block also returns the divide ratio that the PLL output clock select must use:

- While the lock bit is 0, the ratio is a fixed 4.
- While the lock bit is 1, the ratio is the post-divider setting plus one.

The power-on reset is asynchronous and initialises everything. The system reset is synchronous. It clears the timer and change flags, but it leaves the reset-cause flags intact so that software can read them after the reset they report.

Top module: `clkrst_status_reg`

## Requirements
- R1: After power-on reset with all inputs low, the register reads 8'h40. Only bit 6, the power-on flag, is 1. The interrupt output is 0 and the divide ratio is 4.
- R2: A bus write (reg_sel=1, reg_wr=1) clears each flag bit (7, 6, 5, 4, 2, 1) whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R3: Bits 3 (lock status) and 0 (oscillator status) are read-only. Writes never change them.
- R4: A transition of pll_lock_i in either direction is visible on bit 3 two clock edges later. On the following edge it sets bit 4 (lock change), and it sets that flag only once per transition.
- R5: A transition of osc_ok_i in either direction is visible on bit 0 two edges later. On the following edge it sets bit 1 (oscillator change).
- R6: A one-cycle pulse on tmr_expire_i sets bit 7 at the next clock edge.
- R7: When a hardware set and a write-1 clear reach the same flag on the same edge, the flag ends up 1.
- R8: While full_stop_i is 1, bit 0 reads 0. The resulting change of bit 0, on entry to full stop and again on exit, sets bit 1.
- R9: While rst_n is low, bits 7, 4 and 1 clear. Bits 6, 5 and 2 keep their values. A pulse on lvr_event_i or ila_event_i still sets bit 5 or bit 2 while rst_n is low.
- R10: irq_o equals, one edge later, the OR of (bit 7 AND tmr_ie_i), (bit 4 AND lock_ie_i) and (bit 1 AND osc_ie_i).
- R11: pll_div_o is 4 while bit 3 is 0, and postdiv_i+1 while bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | Write qualifier for the access |
| reg_wdata | input | 8 | Write data: a 1 clears the matching flag |
| reg_rdata | output | 8 | Register contents, always presented |
| tmr_expire_i | input | 1 | Timer period end pulse |
| lvr_event_i | input | 1 | Low-voltage reset event pulse |
| ila_event_i | input | 1 | Illegal-address reset event pulse |
| pll_lock_i | input | 1 | Asynchronous PLL lock level |
| osc_ok_i | input | 1 | Asynchronous oscillator qualified level |
| full_stop_i | input | 1 | Full stop mode active |
| tmr_ie_i | input | 1 | Timer flag interrupt enable |
| lock_ie_i | input | 1 | Lock change interrupt enable |
| osc_ie_i | input | 1 | Oscillator change interrupt enable |
| postdiv_i | input | POSTDIV_W | PLL post-divider setting |
| irq_o | output | 1 | Registered combined interrupt request |
| pll_div_o | output | POSTDIV_W+1 | Divide ratio for the PLL output clock |

## Verification
The assertions assume several things about the inputs:

- Event pulses and full_stop_i are synchronous to clk.
- Both resets are held for several cycles at start-up, so that the synchroniser and edge registers hold known values before any edge-based property is evaluated.
- Bus clears are never issued while rst_n is low.

The stimulus follows these assumptions. Every input is driven on the falling edge. Both resets are held low for several cycles before release. The random phase changes one input per step and then lets the register settle for four cycles before it is compared with the bench model. Simultaneous set and clear is exercised only in a directed case.

// File: rtl/clkrst_pkg.sv
// Package: bit positions and per-bit behaviour masks of the status flag register.
// Assumes an 8-bit register; bit order is fixed because software decodes it.
package clkrst_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned BIT_TMR    = 7;
    localparam int unsigned BIT_POR    = 6;
    localparam int unsigned BIT_LVR    = 5;
    localparam int unsigned BIT_LCKCHG = 4;
    localparam int unsigned BIT_LCK    = 3;
    localparam int unsigned BIT_ILA    = 2;
    localparam int unsigned BIT_OSCCHG = 1;
    localparam int unsigned BIT_OSC    = 0;

    // Bits that are write-1-to-clear flags (the rest are live status).
    localparam logic [REG_W-1:0] FLAG_MASK = 8'b1111_0110;
    // Flags that survive the system reset (reset causes).
    localparam logic [REG_W-1:0] KEEP_MASK = 8'b0110_0100;
    // Value loaded by the power-on reset.
    localparam logic [REG_W-1:0] POR_VALUE = 8'b0100_0000;
    // Flags that can raise the interrupt request.
    localparam logic [REG_W-1:0] IRQ_MASK  = 8'b1001_0010;
endpackage

// File: rtl/status_sync.sv
// Module: two-flop synchroniser for a vector of independent slow levels.
// Assumes each bit is a quasi-static level; no bus coherency is implied.
module status_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages per bit, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/change_detect.sv
// Module: flags any transition of each bit of a synchronous level vector.
// Assumes the level is already synchronous; output is high for one cycle per change.
module change_detect #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level so either edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign chg = level ^ prev_q;
endmodule

// File: rtl/w1c_flag.sv
// Module: one sticky flag, set by hardware, cleared by writing 1.
// Assumes set has priority over clear; KEEP selects survival of the system reset.
module w1c_flag #(
    parameter logic RST_VAL = 1'b0,
    parameter logic KEEP    = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Power-on loads RST_VAL; system reset clears unless KEEP; set beats clear.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                q <= RST_VAL;
        else if (!rst_n && !KEEP)  q <= 1'b0;
        else if (set)              q <= 1'b1;
        else if (clr)              q <= 1'b0;
    end
endmodule

// File: rtl/clkrst_status_reg.sv
// Module: status and interrupt flag register of the clock/reset/power unit.
// Assumes event pulses, full_stop_i and bus signals are synchronous to clk;
// pll_lock_i and osc_ok_i may be asynchronous and are synchronised here.
module clkrst_status_reg
    import clkrst_pkg::*;
#(
    parameter int unsigned POSTDIV_W = 5
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 tmr_expire_i,
    input  logic                 lvr_event_i,
    input  logic                 ila_event_i,
    input  logic                 pll_lock_i,
    input  logic                 osc_ok_i,
    input  logic                 full_stop_i,
    input  logic                 tmr_ie_i,
    input  logic                 lock_ie_i,
    input  logic                 osc_ie_i,
    input  logic [POSTDIV_W-1:0] postdiv_i,
    output logic                 irq_o,
    output logic [POSTDIV_W:0]   pll_div_o
);
    localparam int unsigned   RATIO_W     = POSTDIV_W + 1;
    localparam int unsigned   NUM_STATUS  = 2;
    localparam logic [RATIO_W-1:0] UNLOCK_RATIO = RATIO_W'(4);

    logic [NUM_STATUS-1:0] st_sync;
    logic [NUM_STATUS-1:0] st_live;
    logic [NUM_STATUS-1:0] st_chg;
    logic                  lock_live;
    logic                  osc_live;
    logic [REG_W-1:0]      set_vec;
    logic [REG_W-1:0]      clr_vec;
    logic [REG_W-1:0]      en_vec;
    logic [REG_W-1:0]      flag_q;
    logic                  irq_q;

    status_sync #(.W(NUM_STATUS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_lock_i, osc_ok_i}),
        .q     (st_sync)
    );

    // Full stop mode forces the oscillator status low before edge detection.
    assign lock_live = st_sync[1];
    assign osc_live  = st_sync[0] & ~full_stop_i;
    assign st_live   = {lock_live, osc_live};

    change_detect #(.W(NUM_STATUS)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .level (st_live),
        .chg   (st_chg)
    );

    // Hardware set sources per bit position.
    always_comb begin
        set_vec             = '0;
        set_vec[BIT_TMR]    = tmr_expire_i;
        set_vec[BIT_LVR]    = lvr_event_i;
        set_vec[BIT_LCKCHG] = st_chg[1];
        set_vec[BIT_ILA]    = ila_event_i;
        set_vec[BIT_OSCCHG] = st_chg[0];
    end

    // Write-1 clears, ignored while the system reset is active.
    assign clr_vec = (reg_sel && reg_wr && rst_n) ? reg_wdata : '0;

    // One sticky flag per flag bit, live status for the other bits.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (FLAG_MASK[i]) begin : g_flag
            w1c_flag #(
                .RST_VAL (POR_VALUE[i]),
                .KEEP    (KEEP_MASK[i])
            ) u_flag (
                .clk   (clk),
                .por_n (por_n),
                .rst_n (rst_n),
                .set   (set_vec[i]),
                .clr   (clr_vec[i]),
                .q     (flag_q[i])
            );
        end else if (i == BIT_LCK) begin : g_lock
            assign flag_q[i] = lock_live;
        end else begin : g_osc
            assign flag_q[i] = osc_live;
        end
    end

    assign reg_rdata = flag_q;

    // Enable bits aligned with the flags they gate.
    always_comb begin
        en_vec             = '0;
        en_vec[BIT_TMR]    = tmr_ie_i;
        en_vec[BIT_LCKCHG] = lock_ie_i;
        en_vec[BIT_OSCCHG] = osc_ie_i;
    end

    // Registered interrupt request, free of combinational glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & en_vec & IRQ_MASK);
    end

    assign irq_o = irq_q;

    // Divide ratio: fixed 4 until lock, then post-divider plus one.
    assign pll_div_o = lock_live ? (RATIO_W'(postdiv_i) + RATIO_W'(1)) : UNLOCK_RATIO;
endmodule

// File: rtl/clkrst_status_chk.sv
// Module: property checker for clkrst_status_reg, attached by bind.
// Assumes both resets are held for several cycles at start-up.
module clkrst_status_chk #(
    parameter int unsigned POSTDIV_W = 5
) (
    input logic                 clk,
    input logic                 por_n,
    input logic                 rst_n,
    input logic                 reg_sel,
    input logic                 reg_wr,
    input logic [7:0]           reg_wdata,
    input logic [7:0]           reg_rdata,
    input logic                 tmr_expire_i,
    input logic                 lvr_event_i,
    input logic                 ila_event_i,
    input logic                 pll_lock_i,
    input logic                 osc_ok_i,
    input logic                 full_stop_i,
    input logic                 tmr_ie_i,
    input logic                 lock_ie_i,
    input logic                 osc_ie_i,
    input logic [POSTDIV_W-1:0] postdiv_i,
    input logic                 irq_o,
    input logic [POSTDIV_W:0]   pll_div_o
);
    logic irq_src;
    assign irq_src = (reg_rdata[7] & tmr_ie_i) | (reg_rdata[4] & lock_ie_i)
                   | (reg_rdata[1] & osc_ie_i);

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (reg_sel && reg_wr && reg_wdata[7] && !tmr_expire_i) |=> !reg_rdata[7]);

    // R2
    write0_keep_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (reg_sel && reg_wr && !reg_wdata[5] && reg_rdata[5]) |=> reg_rdata[5]);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        tmr_expire_i |=> reg_rdata[7]);

    // R4
    lock_edge_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (reg_rdata[3] != $past(reg_rdata[3])) |=> reg_rdata[4]);

    // R5
    osc_edge_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (reg_rdata[0] != $past(reg_rdata[0])) |=> reg_rdata[1]);

    // R8
    stop_forces_osc_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        full_stop_i |-> !reg_rdata[0]);

    // R9
    cause_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && reg_rdata[5] && reg_rdata[2]) |=> (reg_rdata[5] && reg_rdata[2]));

    // R10
    irq_on_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        irq_src |=> irq_o);

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !irq_src |=> !irq_o);

    // R11
    div_unlock_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !reg_rdata[3] |-> (pll_div_o == (POSTDIV_W+1)'(4)));
endmodule

bind clkrst_status_reg clkrst_status_chk #(.POSTDIV_W(POSTDIV_W)) u_chk (.*);

// File: tb/tb_clkrst_status_reg.sv
module tb_clkrst_status_reg;
    localparam int unsigned PD_W = 5;

    logic            clk = 1'b0;
    logic            por_n, rst_n, reg_sel, reg_wr;
    logic [7:0]      reg_wdata, reg_rdata;
    logic            tmr_expire_i, lvr_event_i, ila_event_i;
    logic            pll_lock_i, osc_ok_i, full_stop_i;
    logic            tmr_ie_i, lock_ie_i, osc_ie_i;
    logic [PD_W-1:0] postdiv_i;
    logic            irq_o;
    logic [PD_W:0]   pll_div_o;

    int n_checks = 0;
    int n_errors = 0;

    // Reference model state.
    logic [7:0] m_flags;

    always #2 clk = ~clk;

    clkrst_status_reg #(.POSTDIV_W(PD_W)) dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: tmr_expire_i = 1'b1;
            1: lvr_event_i  = 1'b1;
            default: ila_event_i = 1'b1;
        endcase
        @(negedge clk);
        tmr_expire_i = 1'b0; lvr_event_i = 1'b0; ila_event_i = 1'b0;
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] f, input logic lk,
                                            input logic osc, input logic stp);
        return (f & 8'hF6) | {4'b0, lk, 2'b0, osc & ~stp};
    endfunction

    function automatic logic exp_irq(input logic [7:0] f, input logic t, input logic l,
                                     input logic o);
        return (f[7] & t) | (f[4] & l) | (f[1] & o);
    endfunction

    function automatic logic [7:0] exp_div(input logic lk, input logic [PD_W-1:0] pd);
        return lk ? 8'(pd) + 8'd1 : 8'd4;
    endfunction

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        por_n = 0; rst_n = 0; reg_sel = 0; reg_wr = 0; reg_wdata = '0;
        tmr_expire_i = 0; lvr_event_i = 0; ila_event_i = 0;
        pll_lock_i = 0; osc_ok_i = 0; full_stop_i = 0;
        tmr_ie_i = 0; lock_ie_i = 0; osc_ie_i = 0; postdiv_i = 5'd9;
        idle(3); por_n = 1; idle(2); rst_n = 1; idle(1);

        // R1 reset state
        chk("R1 read", reg_rdata, 8'h40);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk("R1 div", 8'(pll_div_o), 8'd4);

        // R2 write 0 keeps, write 1 clears
        bus_write(8'h00);
        chk("R2 write0", reg_rdata, 8'h40);
        bus_write(8'h40);
        chk("R2 write1", reg_rdata, 8'h00);

        // R3 live bits not writable (writing all ones with status low)
        bus_write(8'hFF);
        chk("R3 live", reg_rdata, 8'h00);

        // R6 / R10 timer flag and registered irq
        tmr_ie_i = 1;
        pulse(0);
        chk("R6 tmr set", reg_rdata, 8'h80);
        chk("R10 irq not yet", {7'b0, irq_o}, 8'h00);
        idle(1);
        chk("R10 irq high", {7'b0, irq_o}, 8'h01);
        tmr_ie_i = 0; idle(1);
        chk("R10 irq masked", {7'b0, irq_o}, 8'h00);

        // R7 set beats clear in the same cycle
        tmr_expire_i = 1; reg_sel = 1; reg_wr = 1; reg_wdata = 8'h80;
        @(negedge clk);
        tmr_expire_i = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 8'h00;
        chk("R7 set wins", reg_rdata, 8'h80);
        bus_write(8'h80);
        chk("R2 clear tmr", reg_rdata, 8'h00);

        // R4 lock edge latency and R11 divider
        pll_lock_i = 1; idle(1);
        chk("R4 lock edge1", reg_rdata, 8'h00);
        idle(1);
        chk("R4 lock edge2", reg_rdata, 8'h08);
        chk("R11 div locked", 8'(pll_div_o), 8'd10);
        idle(1);
        chk("R4 lock flag", reg_rdata, 8'h18);
        idle(2);
        bus_write(8'h10);
        chk("R4 flag once", reg_rdata, 8'h08);
        pll_lock_i = 0; idle(3);
        chk("R4 falling edge", reg_rdata, 8'h10);
        chk("R11 div unlocked", 8'(pll_div_o), 8'd4);
        bus_write(8'h10);

        // R5 oscillator edge, R8 full stop entry and exit
        osc_ok_i = 1; idle(3);
        chk("R5 osc rise", reg_rdata, 8'h03);
        bus_write(8'h02);
        full_stop_i = 1; idle(1);
        chk("R8 stop entry", reg_rdata, 8'h02);
        bus_write(8'h02);
        full_stop_i = 0; idle(1);
        chk("R8 stop exit", reg_rdata, 8'h03);
        bus_write(8'h02);
        osc_ok_i = 0; idle(3);
        chk("R5 osc fall", reg_rdata, 8'h02);
        bus_write(8'hFF);

        // R9 system reset keeps causes, events still record during reset
        pulse(0);
        rst_n = 0;
        pulse(1);
        pulse(2);
        idle(1); rst_n = 1; idle(1);
        chk("R9 keep causes", reg_rdata, 8'h24);
        bus_write(8'hFF);

        // Random phase with reference model
        m_flags = 8'h00;
        for (int it = 0; it < 400; it++) begin
            int act;
            logic [7:0] w;
            logic old_osc;
            tmr_ie_i  = 1'($urandom);
            lock_ie_i = 1'($urandom);
            osc_ie_i  = 1'($urandom);
            postdiv_i = PD_W'($urandom);
            act = int'($urandom % 7);
            old_osc = osc_ok_i & ~full_stop_i;
            case (act)
                0: begin pulse(0); m_flags[7] = 1; end
                1: begin pulse(1); m_flags[5] = 1; end
                2: begin pulse(2); m_flags[2] = 1; end
                3: begin
                    w = 8'($urandom);
                    bus_write(w);
                    m_flags = m_flags & ~(w & 8'hF6);
                end
                4: begin pll_lock_i = ~pll_lock_i; m_flags[4] = 1; end
                5: begin
                    osc_ok_i = ~osc_ok_i;
                    if ((osc_ok_i & ~full_stop_i) != old_osc) m_flags[1] = 1;
                end
                default: begin
                    full_stop_i = ~full_stop_i;
                    if ((osc_ok_i & ~full_stop_i) != old_osc) m_flags[1] = 1;
                end
            endcase
            idle(4);
            chk("R2 R4 R5 R6 R8 random read", reg_rdata,
                exp_read(m_flags, pll_lock_i, osc_ok_i, full_stop_i));
            chk("R10 random irq", {7'b0, irq_o},
                {7'b0, exp_irq(m_flags, tmr_ie_i, lock_ie_i, osc_ie_i)});
            chk("R11 random div", 8'(pll_div_o), exp_div(pll_lock_i, postdiv_i));
        end

        finish_run();
    end
endmodule